// File: doc/BRIEF.md
# TDD Radio Burst Timing Controller

This block produces the time-division duplex control lines that sequence a radio transceiver and the FPGA sample paths next to it. A frame counter runs from zero to a programmable length minus one and then starts again. Each receive and transmit burst is built from three nested enable layers. The synthesizer comes on first, then the RF path, which takes the radio out of its idle alert state into receive or transmit. The data-path gate, which marks samples as valid, comes on last. The layers come off in the reverse order. Each layer has its own on and off offset inside the frame. The data path may open one window per frame, or a second one as well.

Software loads the frame length, a control word and sixteen offsets through a single-cycle write port. A global run input starts and stops the whole schedule. Writes go into a shadow copy and reach the comparators only at a frame boundary, or at once while the block is stopped. A frame in progress therefore never runs with a half-written schedule.

Top module: `tdd_burst_ctrl`

## Requirements
- R1: While `run` is high the frame counter steps 0, 1, ..., L-1 and then returns to 0, so every output pattern repeats every L cycles, where L is the active frame length. With L equal to 0 or 1 the counter stays at 0.
- R2: Each output is a registered flag. It goes high on the clock edge at which the counter equals its on offset, and low on the edge at which the counter equals its off offset. Otherwise it holds, so a window may span a frame boundary.
- R3: When the on and off offsets of a flag match the counter on the same edge, the flag goes low.
- R4: An offset equal to or greater than the active frame length never sets or clears its flag.
- R5: Receive and transmit have independent offset sets, and they drive six separate outputs: synthesizer, RF and data-path enables for each direction.
- R6: Control bit 0 enables the second receive data window and bit 1 enables the second transmit data window. When the bit is set, the data-path output is the OR of both windows. When it is clear, only the first window drives the output.
- R7: On the first edge with `run` low, all outputs go low and the counter returns to 0. The first edge after `run` rises compares a count of 0.
- R8: Writes to the length, control and offset registers take effect only on the edge where the counter wraps, or on any edge while `run` is low. The frame in progress keeps the old values.
- R9: Address map: 0 sets the frame length and 1 sets the control word. Address 2+8d+s sets an offset, with d = 0 for receive and 1 for transmit. The slot s is 0 synth on, 1 RF on, 2 data window 1 on, 3 data window 1 off, 4 RF off, 5 synth off, 6 data window 2 on, 7 data window 2 off. Writes to addresses 18 to 31 have no effect.
- R10: Reset, synchronous and active low, clears all outputs, the length, the control word and all offsets. An unprogrammed block left running keeps every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Global enable; low holds the counter at 0 and all outputs low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address (see R9) |
| cfg_wdata | input | CNT_W | Register write data |
| rx_synth_en | output | 1 | Receive synthesizer enable |
| tx_synth_en | output | 1 | Transmit synthesizer enable |
| rx_rf_en | output | 1 | Receive RF path enable (alert to receive) |
| tx_rf_en | output | 1 | Transmit RF path enable (alert to transmit) |
| rx_dp_en | output | 1 | Receive data-path valid gate |
| tx_dp_en | output | 1 | Transmit data-path valid gate |

## Verification
The hardest case to reach from the ports is a register write that lands while a frame is running. The old schedule has to finish the current frame, and the new length and offsets must start exactly at the wrap. The stimulus starts a frame, waits until the bench's own count reaches mid-frame, then writes a shorter length and a new offset. It follows the outputs over several frames against a model that holds a pending copy and an active copy of the registers. Separately, a sweep over every on/off pair for frame lengths 1 to 6 includes offsets at and beyond the length and equal on/off pairs. This reaches the off-wins and never-fires corners for all six outputs at once.

// File: rtl/tdd_pkg.sv
// Shared constants and types for the TDD burst timing controller.
// Assumes two directions (receive = 0, transmit = 1) and eight offset
// slots per direction.
package tdd_pkg;

    localparam int NUM_DIR       = 2;
    localparam int NUM_SLOT      = 8;
    localparam int NUM_LAYER     = 4;
    localparam int ADDR_W        = 5;
    localparam int ADDR_LEN      = 0;
    localparam int ADDR_CTRL     = 1;
    localparam int ADDR_PTR_BASE = 2;

    // Offset slot order within one direction; the address map depends on it.
    typedef enum logic [2:0] {
        SLOT_SYN_ON  = 3'd0,
        SLOT_RF_ON   = 3'd1,
        SLOT_DP1_ON  = 3'd2,
        SLOT_DP1_OFF = 3'd3,
        SLOT_RF_OFF  = 3'd4,
        SLOT_SYN_OFF = 3'd5,
        SLOT_DP2_ON  = 3'd6,
        SLOT_DP2_OFF = 3'd7
    } slot_e;

    // Enable layers per direction.
    typedef enum logic [1:0] {
        LAYER_SYN = 2'd0,
        LAYER_RF  = 2'd1,
        LAYER_DP1 = 2'd2,
        LAYER_DP2 = 2'd3
    } layer_e;

    // Slot holding the on offset of a layer.
    function automatic int on_slot(input int layer);
        case (layer)
            0:       return int'(SLOT_SYN_ON);
            1:       return int'(SLOT_RF_ON);
            2:       return int'(SLOT_DP1_ON);
            default: return int'(SLOT_DP2_ON);
        endcase
    endfunction

    // Slot holding the off offset of a layer.
    function automatic int off_slot(input int layer);
        case (layer)
            0:       return int'(SLOT_SYN_OFF);
            1:       return int'(SLOT_RF_OFF);
            2:       return int'(SLOT_DP1_OFF);
            default: return int'(SLOT_DP2_OFF);
        endcase
    endfunction

endpackage

// File: rtl/tdd_frame_counter.sv
// Frame position counter.
// Counts 0..frame_len-1 while run is high, then wraps to 0. It is held at 0
// while run is low. The wrap output marks the edge on which the counter
// returns to 0. Assumes frame_len changes only on a wrap edge or while
// stopped.
module tdd_frame_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W:0] cnt_inc;

    // Next count, one bit wider so the compare cannot overflow.
    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    // Wrap when the next count would reach the frame length.
    assign wrap    = run && (cnt_inc >= {1'b0, frame_len});

    // Frame counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (wrap)   cnt <= '0;
        else             cnt <= cnt_inc[CNT_W-1:0];
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_len != '0) |-> (cnt < frame_len));

    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/tdd_cfg_regs.sv
// Shadow and active configuration registers.
// Writes land in the shadow copy. The active copy, which the comparators
// read, is loaded from the shadow on a frame wrap or on any cycle while
// stopped. Addresses outside the map are ignored.
module tdd_cfg_regs
    import tdd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        we,
    input  logic [ADDR_W-1:0]                           addr,
    input  logic [CNT_W-1:0]                            wdata,
    input  logic                                        run,
    input  logic                                        wrap,
    output logic [CNT_W-1:0]                            act_len,
    output logic [NUM_DIR-1:0]                          act_sec,
    output logic [NUM_DIR-1:0][NUM_SLOT-1:0][CNT_W-1:0] act_ptr
);

    logic               commit;
    logic [CNT_W-1:0]   sh_len;
    logic [NUM_DIR-1:0] sh_sec;

    // Active copy follows the shadow at a boundary or while stopped.
    assign commit = !run || wrap;

    // Shadow frame length and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_len <= '0;
            sh_sec <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_LEN))  sh_len <= wdata;
            if (addr == ADDR_W'(ADDR_CTRL)) sh_sec <= wdata[NUM_DIR-1:0];
        end
    end

    // Active frame length and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len <= '0;
            act_sec <= '0;
        end else if (commit) begin
            act_len <= sh_len;
            act_sec <= sh_sec;
        end
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
            localparam int SLOT_ADDR = ADDR_PTR_BASE + d * NUM_SLOT + s;
            logic [CNT_W-1:0] sh_q;
            logic [CNT_W-1:0] act_q;

            // Shadow offset for this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                                     sh_q <= '0;
                else if (we && addr == ADDR_W'(SLOT_ADDR))      sh_q <= wdata;
            end

            // Active offset for this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)      act_q <= '0;
                else if (commit) act_q <= sh_q;
            end

            assign act_ptr[d][s] = act_q;
        end
    end

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (act_len == $past(act_len)) &&
                           (act_sec == $past(act_sec)) &&
                           (act_ptr == $past(act_ptr)));

    p_cfg_idle_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (act_len == $past(sh_len)) && (act_sec == $past(sh_sec)));

endmodule

// File: rtl/tdd_window_flag.sv
// One on/off window flag.
// The flag sets on the edge where the count equals on_ptr and clears on
// the edge where it equals off_ptr. Off wins a tie. Offsets at or beyond
// frame_len never match. The flag is forced low while act is low.
module tdd_window_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] on_ptr,
    input  logic [CNT_W-1:0] off_ptr,
    output logic             flag
);

    logic on_hit;
    logic off_hit;

    // Match only offsets that lie inside the frame.
    assign on_hit  = (cnt == on_ptr)  && (on_ptr  < frame_len);
    assign off_hit = (cnt == off_ptr) && (off_ptr < frame_len);

    // Window state register.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (!act)    flag <= 1'b0;
        else if (off_hit) flag <= 1'b0;
        else if (on_hit)  flag <= 1'b1;
    end

    p_off_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cnt == off_ptr && off_ptr < frame_len) |=> !flag);

    p_rise_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(on_ptr) < $past(frame_len)) &&
                        ($past(cnt) == $past(on_ptr)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cnt != on_ptr && cnt != off_ptr) |=> (flag == $past(flag)));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !flag);

endmodule

// File: rtl/tdd_burst_ctrl.sv
// TDD burst timing controller, top level.
// Ties the frame counter, the double-buffered configuration and, for each
// direction, four window flags (synthesizer, RF, data window 1 and 2).
// The data-path output ORs both windows. Window 2 runs only when its
// control bit is set.
module tdd_burst_ctrl
    import tdd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic              rx_synth_en,
    output logic              tx_synth_en,
    output logic              rx_rf_en,
    output logic              tx_rf_en,
    output logic              rx_dp_en,
    output logic              tx_dp_en
);

    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    logic [CNT_W-1:0]                            cnt;
    logic                                        wrap;
    logic [CNT_W-1:0]                            act_len;
    logic [NUM_DIR-1:0]                          act_sec;
    logic [NUM_DIR-1:0][NUM_SLOT-1:0][CNT_W-1:0] act_ptr;
    logic [NUM_DIR-1:0][NUM_LAYER-1:0]           lay;

    tdd_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .frame_len (act_len),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    tdd_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .run     (run),
        .wrap    (wrap),
        .act_len (act_len),
        .act_sec (act_sec),
        .act_ptr (act_ptr)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        for (genvar l = 0; l < NUM_LAYER; l++) begin : g_layer
            localparam int ON_IX  = on_slot(l);
            localparam int OFF_IX = off_slot(l);
            logic act_l;
            logic flag_q;

            // Second data window runs only when enabled for this direction.
            if (l == int'(LAYER_DP2)) begin : g_gated
                assign act_l = run && act_sec[d];
            end else begin : g_plain
                assign act_l = run;
            end

            tdd_window_flag #(.CNT_W(CNT_W)) u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .act       (act_l),
                .cnt       (cnt),
                .frame_len (act_len),
                .on_ptr    (act_ptr[d][ON_IX]),
                .off_ptr   (act_ptr[d][OFF_IX]),
                .flag      (flag_q)
            );

            assign lay[d][l] = flag_q;
        end
    end

    assign rx_synth_en = lay[DIR_RX][LAYER_SYN];
    assign tx_synth_en = lay[DIR_TX][LAYER_SYN];
    assign rx_rf_en    = lay[DIR_RX][LAYER_RF];
    assign tx_rf_en    = lay[DIR_TX][LAYER_RF];
    assign rx_dp_en    = lay[DIR_RX][LAYER_DP1] | lay[DIR_RX][LAYER_DP2];
    assign tx_dp_en    = lay[DIR_TX][LAYER_DP1] | lay[DIR_TX][LAYER_DP2];

    p_quiet_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(rx_synth_en | tx_synth_en | rx_rf_en | tx_rf_en |
                   rx_dp_en | tx_dp_en));

    p_sec_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !act_sec[DIR_TX] && !lay[DIR_TX][LAYER_DP1]) |=> $past(lay[DIR_TX][LAYER_DP1]) || !lay[DIR_TX][LAYER_DP2]);

endmodule

// File: tb/tdd_burst_ctrl_tb.sv
// Self-checking bench: sweeps all on/off pairs for small frame lengths and
// compares every cycle against an arithmetic model with pending and active
// register copies.
module tdd_burst_ctrl_tb;
    import tdd_pkg::*;

    localparam int CW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CW-1:0]     cfg_wdata = '0;
    logic rx_synth_en, tx_synth_en, rx_rf_en, tx_rf_en, rx_dp_en, tx_dp_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state
    int len_p = 0, len_a = 0, sec_p = 0, sec_a = 0, mc = 0;
    int ptr_p [2][8];
    int ptr_a [2][8];
    bit mf [2][4];
    int ON_S  [4] = '{0, 1, 2, 6};
    int OFF_S [4] = '{5, 4, 3, 7};

    always #4 clk = ~clk;

    tdd_burst_ctrl #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_synth_en(rx_synth_en), .tx_synth_en(tx_synth_en),
        .rx_rf_en(rx_rf_en), .tx_rf_en(tx_rf_en),
        .rx_dp_en(rx_dp_en), .tx_dp_en(tx_dp_en)
    );

    function automatic bit hit(int p, int c, int l);
        return (p == c) && (p < l);
    endfunction

    task automatic commit_model();
        len_a = len_p;
        sec_a = sec_p;
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 8; s++) ptr_a[d][s] = ptr_p[d][s];
    endtask

    task automatic model_step();
        if (run) begin
            for (int d = 0; d < 2; d++) begin
                for (int l = 0; l < 4; l++) begin
                    bit act = (l == 3) ? ((sec_a >> d) & 1) != 0 : 1'b1;
                    if (!act)                                   mf[d][l] = 1'b0;
                    else if (hit(ptr_a[d][OFF_S[l]], mc, len_a)) mf[d][l] = 1'b0;
                    else if (hit(ptr_a[d][ON_S[l]], mc, len_a))  mf[d][l] = 1'b1;
                end
            end
            if (mc + 1 >= len_a) begin
                mc = 0;
                commit_model();
            end else begin
                mc = mc + 1;
            end
        end else begin
            for (int d = 0; d < 2; d++)
                for (int l = 0; l < 4; l++) mf[d][l] = 1'b0;
            mc = 0;
            commit_model();
        end
    endtask

    task automatic compare(string tag);
        logic [5:0] got, exp;
        got = {rx_synth_en, tx_synth_en, rx_rf_en, tx_rf_en, rx_dp_en, tx_dp_en};
        exp = {mf[0][0], mf[1][0], mf[0][1], mf[1][1],
               mf[0][2] | mf[0][3], mf[1][2] | mf[1][3]};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: outputs %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(int a, int v, string tag);
        cfg_we    = 1'b1;
        cfg_addr  = a[ADDR_W-1:0];
        cfg_wdata = v[CW-1:0];
        cycle(tag);
        if (a == 0)                 len_p = v;
        else if (a == 1)            sec_p = v & 3;
        else if (a >= 2 && a < 18)  ptr_p[(a - 2) / 8][(a - 2) % 8] = v;
        cfg_we = 1'b0;
    endtask

    task automatic wr_ptr(int d, int s, int v, string tag);
        wr(2 + 8 * d + s, v, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 8; s++) begin
                ptr_p[d][s] = 0;
                ptr_a[d][s] = 0;
            end
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 4; l++) mf[d][l] = 1'b0;

        // R10: reset state, then an unprogrammed block left running
        repeat (3) @(negedge clk);
        compare("R10");
        rst_n = 1'b1;
        run   = 1'b1;
        repeat (10) cycle("R10");
        run = 1'b0;
        cycle("R7");

        // R1 R2 R3 R4 R5: sweep all on/off pairs for small frame lengths
        for (int L = 1; L <= 6; L++) begin
            int m = L + 2;
            for (int a = 0; a < m; a++) begin
                for (int b = 0; b < m; b++) begin
                    wr(0, L, "R9");
                    wr(1, 1, "R9");
                    wr_ptr(0, 0, a, "R9");           wr_ptr(0, 5, b, "R9");
                    wr_ptr(0, 1, b, "R9");           wr_ptr(0, 4, a, "R9");
                    wr_ptr(0, 2, a, "R9");           wr_ptr(0, 3, (a + 1) % m, "R9");
                    wr_ptr(0, 6, b, "R9");           wr_ptr(0, 7, (b + 2) % m, "R9");
                    wr_ptr(1, 0, (a + 1) % m, "R9"); wr_ptr(1, 5, b, "R9");
                    wr_ptr(1, 1, a, "R9");           wr_ptr(1, 4, a, "R9");
                    wr_ptr(1, 2, (b + 1) % m, "R9"); wr_ptr(1, 3, a, "R9");
                    wr_ptr(1, 6, a, "R9");           wr_ptr(1, 7, b, "R9");
                    cycle("R7");
                    run = 1'b1;
                    repeat (2 * L + 3) cycle("R1/R2/R3/R4/R5");
                    run = 1'b0;
                    cycle("R7");
                end
            end
        end

        // R7: stop mid-frame, restart from count 0
        wr(0, 8, "R7"); wr(1, 0, "R7");
        wr_ptr(0, 0, 1, "R7"); wr_ptr(0, 5, 6, "R7");
        wr_ptr(0, 1, 2, "R7"); wr_ptr(0, 4, 5, "R7");
        wr_ptr(0, 2, 3, "R7"); wr_ptr(0, 3, 4, "R7");
        wr_ptr(1, 0, 0, "R7"); wr_ptr(1, 5, 7, "R7");
        wr_ptr(1, 1, 6, "R7"); wr_ptr(1, 4, 2, "R7");
        wr_ptr(1, 2, 7, "R7"); wr_ptr(1, 3, 1, "R7");
        cycle("R7");
        run = 1'b1;
        repeat (5) cycle("R7");
        run = 1'b0;
        repeat (3) cycle("R7");
        run = 1'b1;
        repeat (20) cycle("R7");

        // R8: mid-frame writes wait for the wrap
        while (mc != 3) cycle("R8");
        wr(0, 5, "R8");
        wr_ptr(0, 0, 4, "R8");
        wr_ptr(1, 4, 3, "R8");
        repeat (30) cycle("R8");

        // R6: second transmit window gated by control bit 1
        run = 1'b0;
        wr(0, 10, "R6"); wr(1, 0, "R6");
        wr_ptr(1, 2, 1, "R6"); wr_ptr(1, 3, 3, "R6");
        wr_ptr(1, 6, 5, "R6"); wr_ptr(1, 7, 8, "R6");
        wr_ptr(0, 2, 2, "R6"); wr_ptr(0, 3, 4, "R6");
        wr_ptr(0, 6, 4, "R6"); wr_ptr(0, 7, 9, "R6");
        cycle("R6");
        run = 1'b1;
        repeat (20) cycle("R6");
        while (mc != 6) cycle("R6");
        wr(1, 3, "R6");
        repeat (30) cycle("R6");
        wr(1, 2, "R6");
        repeat (25) cycle("R6");

        // R9: unmapped addresses have no effect
        for (int a = 18; a < 32; a++) wr(a, (a * 3) % 8, "R9");
        repeat (25) cycle("R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule